// File: doc/BRIEF.md
# Programmable Parallel Port Control-Word Unit

This block is the register side of a three-port programmable parallel interface. There are three 8-bit ports, called A, B and C. A host writes bytes to four locations. Three of them are the port data latches and the fourth is a control location. A control byte with its top bit set is a configuration word. It chooses the operating mode of ports A and B, and the direction of A, of B and of each half of C. A control byte with its top bit clear is a command that sets or clears one bit of port C.

From the configuration word the block derives a write mask for each port. The mask gives the bits the host may drive. It is presented as an output-enable vector, so the pins can be built as tri-state drivers. When a port runs in a strobed mode, the port C bits that carry its handshake lines are taken out of the port C mask. Single-bit commands aimed at those bits instead load the interrupt-enable flags of the strobed port. After each configuration word, the latches are cleared wherever their bits are no longer writable. The handshake timing and bus read timing live outside this block.

Top module: `ppi_ctrl`

## Requirements
- R1: Reset (synchronous, active low) loads the configuration word from parameter RST_MODE, which defaults to 8'h9B: every port in mode 0 and every port an input. Reset also clears all three latches and all interrupt-enable flags, so every output-enable vector and every data output reads zero.
- R2: A write to location 3 (`wr_sel`=2'b11) with `wr_data[7]`=1 is a configuration word, presented on `mode_word`. In it, bit 4 sets the direction of port A, bit 1 that of port B, bit 3 that of port C[7:4] and bit 0 that of port C[3:0], where 1 means input. An output port or half has an output enable of all ones, and an input port or half has all zeros.
- R3: When configuration bit 2 is 1 (port B in strobed mode 1), port C bits 2:0 are never output-enabled.
- R4: When configuration bits 6:5 are 1x (port A in mode 2), port C bits 7:3 are never output-enabled. When they are 01 (port A in mode 1), port C bits 5:3 are removed if bit 4 is 1 (input), and bits 7, 6 and 3 are removed if bit 4 is 0 (output).
- R5: A configuration word clears every latch bit whose new output enable is 0. Latch bits that stay enabled keep their value. No data output ever shows a 1 where its output enable is 0.
- R6: A write to location 0, 1 or 2 (ports A, B, C) loads `wr_data` into that port's latch in the enabled bit positions only. The other bits are not changed.
- R7: A write to location 3 with `wr_data[7]`=0 is a bit command. Bits 3:1 select a port C bit and bit 0 is the value written to it. Bits 6:4 are ignored. The command changes the selected bit only if that bit is output-enabled, and it never changes `mode_word`.
- R8: In port A mode 2, a bit command to bit 4 loads `inte_a_rx` and one to bit 6 loads `inte_a_tx`. In port A mode 1, only bit 4 loads `inte_a_rx`, and only when A is an input; only bit 6 loads `inte_a_tx`, and only when A is an output. In port A mode 0 neither flag changes. A configuration word leaves the flags as they are.
- R9: When port B is in mode 1, a bit command to bit 2 loads `inte_b`. In every other case `inte_b` is unchanged by bit commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 2 | Target: 0 port A, 1 port B, 2 port C, 3 control |
| wr_data | input | 8 | Write byte |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A output enables |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B output enables |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C output enables |
| inte_a_rx | output | 1 | Port A input-side interrupt enable |
| inte_a_tx | output | 1 | Port A output-side interrupt enable |
| inte_b | output | 1 | Port B interrupt enable |
| mode_word | output | 8 | Current configuration word |

## Verification
The bench builds the block with the default RST_MODE of 8'h9B. This makes the all-input reset state the first thing checked. From that state the bench moves through configuration words that cover all three port A modes, including the 11 encoding of mode 2, both port A directions in mode 1, and port B in mode 1. The latch contents are chosen so that every switch of direction has stale bits to clear. Bit commands are aimed at handshake-owned bits and at ordinary bits, with the ignored bits 6:4 set, to show the gating and the loading of the interrupt-enable flags.

// File: rtl/ppi_pkg.sv
// Shared constants, types and the mask derivation for the parallel port
// control unit. Assumes the fixed 8-bit control-word encoding.
package ppi_pkg;

    localparam int PORT_W  = 8;
    localparam int N_PORTS = 3;
    localparam int SEL_W   = $clog2(N_PORTS + 1);
    localparam int BIT_W   = $clog2(PORT_W);

    typedef logic [PORT_W-1:0] port_t;

    // Write targets on the host side
    typedef enum logic [SEL_W-1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CTL = 2'd3
    } sel_e;

    // Configuration-word field positions (decoded by this block)
    localparam int CW_FLAG   = 7;
    localparam int CW_AMODE2 = 6;
    localparam int CW_AMODE1 = 5;
    localparam int CW_ADIR   = 4;
    localparam int CW_CHIDIR = 3;
    localparam int CW_BMODE  = 2;
    localparam int CW_BDIR   = 1;
    localparam int CW_CLODIR = 0;

    // Port C bits that carry the port A input-side and output-side enables
    localparam int C_RX_BIT = 4;
    localparam int C_TX_BIT = 6;
    localparam int C_B_BIT  = 2;

    typedef struct packed {
        port_t a;
        port_t b;
        port_t c;
    } masks_t;

    // Derive all write masks from one configuration word
    function automatic masks_t derive_masks(input port_t cw);
        masks_t m;
        port_t  strip;
        m.a = cw[CW_ADIR] ? '0 : '1;
        m.b = cw[CW_BDIR] ? '0 : '1;
        m.c = {(cw[CW_CHIDIR] ? 4'h0 : 4'hF), (cw[CW_CLODIR] ? 4'h0 : 4'hF)};
        strip = '0;
        if (cw[CW_BMODE])
            strip = strip | 8'h07;
        if (cw[CW_AMODE2])
            strip = strip | 8'hF8;
        else if (cw[CW_AMODE1])
            strip = strip | (cw[CW_ADIR] ? 8'h38 : 8'hC8);
        m.c = m.c & ~strip;
        return m;
    endfunction

endpackage

// File: rtl/ppi_mode_reg.sv
// Holds the configuration word and presents the write masks derived from it.
// Assumes load is asserted only for words whose flag bit is set.
module ppi_mode_reg
    import ppi_pkg::*;
#(
    parameter port_t RST_MODE = 8'h9B
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  port_t  din,
    output port_t  mode_q,
    output masks_t masks
);

    // Capture a new configuration word
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= RST_MODE;
        else if (load)
            mode_q <= din;
    end

    // Masks follow the stored word
    always_comb masks = derive_masks(mode_q);

endmodule

// File: rtl/ppi_latch.sv
// One port output latch. A clear keeps only the bits in keep_bits; an update
// replaces the bits in upd_bits with upd_val. Assumes clr and upd never coincide.
module ppi_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] keep_bits,
    input  logic         upd_en,
    input  logic [W-1:0] upd_bits,
    input  logic [W-1:0] upd_val,
    output logic [W-1:0] q
);

    // Latch storage with masked clear and masked update
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (clr_en)
            q <= q & keep_bits;
        else if (upd_en)
            q <= (q & ~upd_bits) | (upd_val & upd_bits);
    end

endmodule

// File: rtl/ppi_inte.sv
// Interrupt-enable flags for the strobed modes, loaded by port C bit commands
// that the current configuration routes to them. Assumes cmd_en marks a bit command.
module ppi_inte
    import ppi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_en,
    input  logic [BIT_W-1:0] cmd_bit,
    input  logic             cmd_val,
    input  port_t            mode_q,
    output logic             rx_q,
    output logic             tx_q,
    output logic             b_q
);

    logic a_m2, a_m1, a_in;
    logic hit_rx, hit_tx, hit_b;

    // Decide which flag, if any, the command targets
    always_comb begin
        a_m2   = mode_q[CW_AMODE2];
        a_m1   = !mode_q[CW_AMODE2] && mode_q[CW_AMODE1];
        a_in   = mode_q[CW_ADIR];
        hit_rx = cmd_en && (cmd_bit == BIT_W'(C_RX_BIT)) && (a_m2 || (a_m1 && a_in));
        hit_tx = cmd_en && (cmd_bit == BIT_W'(C_TX_BIT)) && (a_m2 || (a_m1 && !a_in));
        hit_b  = cmd_en && (cmd_bit == BIT_W'(C_B_BIT)) && mode_q[CW_BMODE];
    end

    // Flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= 1'b0;
            tx_q <= 1'b0;
            b_q  <= 1'b0;
        end else begin
            if (hit_rx) rx_q <= cmd_val;
            if (hit_tx) tx_q <= cmd_val;
            if (hit_b)  b_q  <= cmd_val;
        end
    end

endmodule

// File: rtl/ppi_ctrl.sv
// Top of the parallel port control-word unit: decodes host writes, keeps
// the configuration, the three port latches and the interrupt enables.
// Assumes one write per cycle, qualified by wr_en.
module ppi_ctrl
    import ppi_pkg::*;
#(
    parameter logic [7:0] RST_MODE = 8'h9B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] pa_out,
    output logic [7:0] pa_oe,
    output logic [7:0] pb_out,
    output logic [7:0] pb_oe,
    output logic [7:0] pc_out,
    output logic [7:0] pc_oe,
    output logic       inte_a_rx,
    output logic       inte_a_tx,
    output logic       inte_b,
    output logic [7:0] mode_word
);

    logic   ctl_wr, cfg_wr, cmd_wr;
    masks_t cur_m, new_m;
    logic [BIT_W-1:0] cmd_bit;
    port_t  cmd_onehot;

    port_t  keep_v [N_PORTS];
    port_t  mask_v [N_PORTS];
    logic   upd_v  [N_PORTS];
    port_t  bits_v [N_PORTS];
    port_t  val_v  [N_PORTS];
    port_t  q_v    [N_PORTS];

    // Classify the host write
    always_comb begin
        ctl_wr     = wr_en && (wr_sel == SEL_CTL);
        cfg_wr     = ctl_wr && wr_data[CW_FLAG];
        cmd_wr     = ctl_wr && !wr_data[CW_FLAG];
        cmd_bit    = wr_data[BIT_W:1];
        cmd_onehot = port_t'(1) << cmd_bit;
        new_m      = derive_masks(wr_data);
    end

    ppi_mode_reg #(.RST_MODE(RST_MODE)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_wr),
        .din   (wr_data),
        .mode_q(mode_word),
        .masks (cur_m)
    );

    // Per-port controls for the latch array
    always_comb begin
        keep_v[0] = new_m.a;
        keep_v[1] = new_m.b;
        keep_v[2] = new_m.c;
        mask_v[0] = cur_m.a;
        mask_v[1] = cur_m.b;
        mask_v[2] = cur_m.c;
        for (int p = 0; p < N_PORTS; p++) begin
            upd_v[p]  = wr_en && (wr_sel == SEL_W'(p));
            bits_v[p] = mask_v[p];
            val_v[p]  = wr_data;
        end
        if (cmd_wr) begin
            upd_v[2]  = 1'b1;
            bits_v[2] = cur_m.c & cmd_onehot;
            val_v[2]  = {PORT_W{wr_data[0]}};
        end
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_latch
        ppi_latch #(.W(PORT_W)) u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_en   (cfg_wr),
            .keep_bits(keep_v[p]),
            .upd_en   (upd_v[p]),
            .upd_bits (bits_v[p]),
            .upd_val  (val_v[p]),
            .q        (q_v[p])
        );
    end

    ppi_inte u_inte (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_en (cmd_wr),
        .cmd_bit(cmd_bit),
        .cmd_val(wr_data[0]),
        .mode_q (mode_word),
        .rx_q   (inte_a_rx),
        .tx_q   (inte_a_tx),
        .b_q    (inte_b)
    );

    // Drive the port outputs
    always_comb begin
        pa_out = q_v[0];
        pb_out = q_v[1];
        pc_out = q_v[2];
        pa_oe  = cur_m.a;
        pb_oe  = cur_m.b;
        pc_oe  = cur_m.c;
    end

endmodule

// File: rtl/ppi_ctrl_chk.sv
// Property checker for ppi_ctrl, attached by bind. Observes ports only.
module ppi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe,
    input logic       inte_b,
    input logic [7:0] mode_word
);

    // R2
    a_port_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF));

    // R3
    b_hs_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_word[2] |-> (pc_oe[2:0] == 3'b000));

    // R4
    a_m2_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_word[6] |-> (pc_oe[7:3] == 5'b00000));

    // R5
    no_stale_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pa_out & ~pa_oe) == 8'h00) && ((pb_out & ~pb_oe) == 8'h00) && ((pc_out & ~pc_oe) == 8'h00));

    // R7
    cmd_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b11 && !wr_data[7]) |=> $stable(mode_word));

    // R9
    inte_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b11 && !wr_data[7] && !mode_word[2]) |=> $stable(inte_b));

endmodule

bind ppi_ctrl ppi_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .pa_out   (pa_out),
    .pa_oe    (pa_oe),
    .pb_out   (pb_out),
    .pb_oe    (pb_oe),
    .pc_out   (pc_out),
    .pc_oe    (pc_oe),
    .inte_b   (inte_b),
    .mode_word(mode_word)
);

// File: tb/sim_ppi_ctrl.sv
`timescale 1ns/1ps
module sim_ppi_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'b00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe, mode_word;
    logic       inte_a_rx, inte_a_tx, inte_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [58:0] exp;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    ppi_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_out(pc_out), .pc_oe(pc_oe), .inte_a_rx(inte_a_rx), .inte_a_tx(inte_a_tx),
        .inte_b(inte_b), .mode_word(mode_word)
    );

    // One host write, applied at the posedge between two negedges
    task automatic put(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Push an expected output snapshot
    task automatic expect_st(input string tag,
        input logic [7:0] a, ao, b, bo, c, co,
        input logic rx, tx, ib, input logic [7:0] m);
        item_t it;
        it.tag = tag;
        it.exp = {a, ao, b, bo, c, co, rx, tx, ib, m};
        sb.push_back(it);
    endtask

    // Monitor: pop and compare away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() != 0) begin
                item_t it;
                logic [58:0] act;
                it = sb.pop_front();
                act = {pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe,
                       inte_a_rx, inte_a_tx, inte_b, mode_word};
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_st("R1 reset", 8'h00,8'h00, 8'h00,8'h00, 8'h00,8'h00, 0,0,0, 8'h9B);
        put(2'd3, 8'h80);
        expect_st("R2 all out", 8'h00,8'hFF, 8'h00,8'hFF, 8'h00,8'hFF, 0,0,0, 8'h80);
        put(2'd0, 8'h5A); put(2'd1, 8'hC3); put(2'd2, 8'h96);
        expect_st("R6 data", 8'h5A,8'hFF, 8'hC3,8'hFF, 8'h96,8'hFF, 0,0,0, 8'h80);
        put(2'd3, 8'h01);
        expect_st("R7 set bit0", 8'h5A,8'hFF, 8'hC3,8'hFF, 8'h97,8'hFF, 0,0,0, 8'h80);
        put(2'd3, 8'h77);
        expect_st("R7 ignored 6:4", 8'h5A,8'hFF, 8'hC3,8'hFF, 8'h9F,8'hFF, 0,0,0, 8'h80);
        put(2'd3, 8'h89);
        expect_st("R5 C input clears", 8'h5A,8'hFF, 8'hC3,8'hFF, 8'h00,8'h00, 0,0,0, 8'h89);
        put(2'd2, 8'hFF);
        expect_st("R6 gated C", 8'h5A,8'hFF, 8'hC3,8'hFF, 8'h00,8'h00, 0,0,0, 8'h89);
        put(2'd3, 8'h0B);
        expect_st("R7 gated cmd", 8'h5A,8'hFF, 8'hC3,8'hFF, 8'h00,8'h00, 0,0,0, 8'h89);
        put(2'd3, 8'h90);
        expect_st("R5 A input clears", 8'h00,8'h00, 8'hC3,8'hFF, 8'h00,8'hFF, 0,0,0, 8'h90);
        put(2'd0, 8'hFF);
        expect_st("R6 gated A", 8'h00,8'h00, 8'hC3,8'hFF, 8'h00,8'hFF, 0,0,0, 8'h90);
        put(2'd3, 8'h84);
        expect_st("R3 B mode1 mask", 8'h00,8'hFF, 8'hC3,8'hFF, 8'h00,8'hF8, 0,0,0, 8'h84);
        put(2'd2, 8'hFF);
        expect_st("R3 C write", 8'h00,8'hFF, 8'hC3,8'hFF, 8'hF8,8'hF8, 0,0,0, 8'h84);
        put(2'd3, 8'h05);
        expect_st("R9 inte_b set", 8'h00,8'hFF, 8'hC3,8'hFF, 8'hF8,8'hF8, 0,0,1, 8'h84);
        put(2'd3, 8'h02);
        expect_st("R9 bit1 no inte", 8'h00,8'hFF, 8'hC3,8'hFF, 8'hF8,8'hF8, 0,0,1, 8'h84);
        put(2'd3, 8'hA0);
        expect_st("R4 A m1 out", 8'h00,8'hFF, 8'hC3,8'hFF, 8'h30,8'h37, 0,0,1, 8'hA0);
        put(2'd3, 8'h0D);
        expect_st("R8 m1 out tx", 8'h00,8'hFF, 8'hC3,8'hFF, 8'h30,8'h37, 0,1,1, 8'hA0);
        put(2'd3, 8'h09);
        expect_st("R8 m1 out bit4 plain", 8'h00,8'hFF, 8'hC3,8'hFF, 8'h30,8'h37, 0,1,1, 8'hA0);
        put(2'd3, 8'h08);
        expect_st("R8 m1 out bit4 clr", 8'h00,8'hFF, 8'hC3,8'hFF, 8'h20,8'h37, 0,1,1, 8'hA0);
        put(2'd3, 8'hB0);
        expect_st("R4 A m1 in", 8'h00,8'h00, 8'hC3,8'hFF, 8'h00,8'hC7, 0,1,1, 8'hB0);
        put(2'd3, 8'h09);
        expect_st("R8 m1 in rx", 8'h00,8'h00, 8'hC3,8'hFF, 8'h00,8'hC7, 1,1,1, 8'hB0);
        put(2'd3, 8'hC0);
        expect_st("R4 A m2", 8'h00,8'hFF, 8'hC3,8'hFF, 8'h00,8'h07, 1,1,1, 8'hC0);
        put(2'd2, 8'hFF);
        put(2'd3, 8'h08);
        put(2'd3, 8'h0C);
        expect_st("R8 m2 both clr", 8'h00,8'hFF, 8'hC3,8'hFF, 8'h07,8'h07, 0,0,1, 8'hC0);
        put(2'd3, 8'hE0);
        expect_st("R4 A m2 code 11", 8'h00,8'hFF, 8'hC3,8'hFF, 8'h07,8'h07, 0,0,1, 8'hE0);
        put(2'd3, 8'h80);
        put(2'd3, 8'h09);
        expect_st("R8 m0 no inte", 8'h00,8'hFF, 8'hC3,8'hFF, 8'h17,8'hFF, 0,0,1, 8'h80);
        put(2'd3, 8'h0D);
        expect_st("R8 m0 bit6", 8'h00,8'hFF, 8'hC3,8'hFF, 8'h57,8'hFF, 0,0,1, 8'h80);
        wait (sb.size() == 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule